// File: doc/BRIEF.md
# Debug Exception Entry and Return Controller

This block owns the debug-mode control path of a small 32-bit processor core whose branches have one delay slot. It holds two coprocessor-0 registers: a debug status word and the saved debug return address. When the core raises a debug breakpoint outside debug mode, the block records where to resume. It notes whether the trapping instruction was in a branch delay slot, and if so it backs the saved address up to the branch and cancels the pending branch. It then marks debug mode and sends fetch to the fixed debug handler address.

The debug-return instruction leaves debug mode. It jumps back to the saved address after one more instruction, which is the return's own delay slot. The block also serves coprocessor-0 moves to and from its two registers. It keeps the load-linked reservation flag, which every signalled exception clears so that a pending atomic read-modify-write sequence fails.

Top module: `dbg_entry_ctl`

## Requirements
- R1: While reset is asserted and after its release, the status word and the saved address read as zero, the reservation flag is low, and neither redirect nor cancel is asserted.
- R2: A breakpoint request taken with debug mode clear is followed, after the next clock edge, by a one-cycle redirect to address 0xBFC00200. From then on the status word reads debug mode (bit 30) and breakpoint cause (bit 1) set, and the debug-mode output is high.
- R3: When the trapping instruction is not in a delay slot, entry clears the delay-slot flag (bit 31), saves the instruction address itself, and gives no cancel pulse.
- R4: When the trapping instruction is in a delay slot, entry sets the delay-slot flag (bit 31), saves the instruction address minus 4, and pulses the cancel output in the same cycle as the redirect.
- R5: A breakpoint request that arrives while debug mode is set gives no redirect and leaves both registers unchanged.
- R6: A load-linked set input raises the reservation flag. A breakpoint request (taken or suppressed) or any other exception input clears it on the next edge, and clearing wins over setting.
- R7: A coprocessor-0 access with code 0x00 returns register 16 (status word) or register 17 (saved address) on the read data output in the same cycle. Code 0x04 writes the supplied data on the next edge. Every other register number reads zero and ignores writes.
- R8: Only bits 31, 30 and 1 of the status word are stored. All other bits read zero whatever is written.
- R9: Code 0x10 with function 0x1F (debug return) clears debug mode on the next edge and latches the saved address. No redirect follows until a later cycle with a valid instruction, which is the delay slot. On the edge after that cycle, a one-cycle redirect to the latched address is given.
- R10: A breakpoint taken in the same cycle as a debug return discards the return. A breakpoint taken while a return is waiting for its delay slot cancels that return.
- R11: Each redirect lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| brkReq | input | 1 | Debug breakpoint request for the current instruction |
| excReq | input | 1 | Any other exception signalled this cycle |
| instValid | input | 1 | A valid instruction occupies the current cycle |
| instPc | input | 32 | Address of the current instruction |
| inDelaySlot | input | 1 | Current instruction sits in a branch delay slot |
| cpValid | input | 1 | Decoded coprocessor-0 operation present |
| cpCode | input | 5 | Coprocessor-0 code field (0x00 read, 0x04 write, 0x10 control op) |
| cpFunct | input | 6 | Low six instruction bits (0x1F is debug return) |
| cpReg | input | 5 | Coprocessor-0 register number |
| cpWData | input | 32 | Data for a coprocessor-0 write |
| llSet | input | 1 | Load-linked executed; raise the reservation |
| redirValid | output | 1 | One-cycle fetch redirect strobe |
| redirPc | output | 32 | Fetch redirect target |
| cancelDs | output | 1 | Cancel the pending delay-slot branch |
| cpRData | output | 32 | Coprocessor-0 read data |
| debugMode | output | 1 | Debug mode currently set |
| llValid | output | 1 | Load-linked reservation flag |

## Verification
The hardest situation to reach is a debug return that is waiting for its delay slot while another event arrives. That event can be an idle cycle without a valid instruction, a new breakpoint, or a breakpoint in the same cycle as the return. The bench reaches each one by holding back the instruction-valid strobe for chosen cycles after the return, and by driving the breakpoint and return decodes in the same cycle or just after it. This is done inside a sweep over many instruction addresses (including the zero address, where backing up wraps) in both delay-slot states, so every entry is followed by a suppressed entry and by a full return.

// File: rtl/dbg_ctl_pkg.sv
package dbg_ctl_pkg;

  // coprocessor-0 operation codes understood by this block
  localparam logic [4:0] CP_READ  = 5'h00;
  localparam logic [4:0] CP_WRITE = 5'h04;
  localparam logic [4:0] CP_CTRL  = 5'h10;
  localparam logic [5:0] FN_DRET  = 6'h1F;

  // strobes handed from the sequencer to the register datapath
  typedef struct packed {
    logic enter;      // take debug entry this cycle
    logic enterInDs;  // entry is from a delay slot
    logic dret;       // debug return accepted
    logic fireRet;    // delay slot done, jump back
    logic wrStat;     // write status word
    logic wrSave;     // write saved address
  } dbgStrobe_t;

endpackage

// File: rtl/dbg_ctl_seq.sv
module dbg_ctl_seq
  import dbg_ctl_pkg::*;
#(
  parameter int REG_STAT = 16,
  parameter int REG_SAVE = 17
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       brkReq,
  input  logic       instValid,
  input  logic       inDelaySlot,
  input  logic       cpValid,
  input  logic [4:0] cpCode,
  input  logic [5:0] cpFunct,
  input  logic [4:0] cpReg,
  input  logic       dmNow,
  output dbgStrobe_t strb,
  output logic       redirValid,
  output logic       cancelDs
);

  logic brkTaken;
  logic isDret;
  logic isWrite;
  logic retPending;
  logic retPendingNext;

  always_comb begin
    brkTaken = brkReq & ~dmNow;
    isDret   = cpValid && (cpCode == CP_CTRL) && (cpFunct == FN_DRET);
    isWrite  = cpValid && (cpCode == CP_WRITE);

    strb.enter     = brkTaken;
    strb.enterInDs = brkTaken & inDelaySlot;
    strb.dret      = isDret & ~brkTaken;
    strb.fireRet   = retPending & instValid & ~brkTaken;
    strb.wrStat    = isWrite && (cpReg == 5'(REG_STAT)) && !brkTaken;
    strb.wrSave    = isWrite && (cpReg == 5'(REG_SAVE)) && !brkTaken;

    if (brkTaken)          retPendingNext = 1'b0;
    else if (strb.dret)    retPendingNext = 1'b1;
    else if (strb.fireRet) retPendingNext = 1'b0;
    else                   retPendingNext = retPending;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retPending <= 1'b0;
      redirValid <= 1'b0;
      cancelDs   <= 1'b0;
    end else begin
      retPending <= retPendingNext;
      redirValid <= brkTaken | strb.fireRet;
      cancelDs   <= brkTaken & inDelaySlot;
    end
  end

endmodule

// File: rtl/dbg_ctl_dp.sv
module dbg_ctl_dp
  import dbg_ctl_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] VEC        = 32'hBFC0_0200,
  parameter int          REG_STAT   = 16,
  parameter int          REG_SAVE   = 17
) (
  input  logic            clk,
  input  logic            rstN,
  input  dbgStrobe_t      strb,
  input  logic [XLEN-1:0] instPc,
  input  logic [XLEN-1:0] cpWData,
  input  logic            cpValid,
  input  logic [4:0]      cpCode,
  input  logic [4:0]      cpReg,
  input  logic            brkReq,
  input  logic            excReq,
  input  logic            llSet,
  output logic            dmNow,
  output logic [XLEN-1:0] redirPc,
  output logic [XLEN-1:0] cpRData,
  output logic            llValid
);

  localparam int DS_BIT = XLEN - 1;
  localparam int DM_BIT = XLEN - 2;
  localparam int BP_BIT = 1;

  logic            dsFlag;
  logic            dmFlag;
  logic            bpFlag;
  logic [XLEN-1:0] savePc;
  logic [XLEN-1:0] retTarget;
  logic [XLEN-1:0] statWord;

  always_comb begin
    statWord         = '0;
    statWord[DS_BIT] = dsFlag;
    statWord[DM_BIT] = dmFlag;
    statWord[BP_BIT] = bpFlag;
  end

  always_comb begin
    cpRData = '0;
    if (cpValid && cpCode == CP_READ) begin
      if (cpReg == 5'(REG_STAT))      cpRData = statWord;
      else if (cpReg == 5'(REG_SAVE)) cpRData = savePc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dsFlag    <= 1'b0;
      dmFlag    <= 1'b0;
      bpFlag    <= 1'b0;
      savePc    <= '0;
      retTarget <= '0;
      redirPc   <= '0;
    end else if (strb.enter) begin
      dsFlag  <= strb.enterInDs;
      dmFlag  <= 1'b1;
      bpFlag  <= 1'b1;
      savePc  <= strb.enterInDs ? instPc - XLEN'(INSN_BYTES) : instPc;
      redirPc <= XLEN'(VEC);
    end else begin
      if (strb.wrStat) begin
        dsFlag <= cpWData[DS_BIT];
        dmFlag <= cpWData[DM_BIT];
        bpFlag <= cpWData[BP_BIT];
      end
      if (strb.wrSave) savePc <= cpWData;
      if (strb.dret) begin
        dmFlag    <= 1'b0;
        retTarget <= savePc;
      end
      if (strb.fireRet) redirPc <= retTarget;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  llValid <= 1'b0;
    else if (brkReq || excReq)  llValid <= 1'b0;
    else if (llSet)             llValid <= 1'b1;
  end

  assign dmNow = dmFlag;

endmodule

// File: rtl/dbg_entry_ctl.sv
module dbg_entry_ctl
  import dbg_ctl_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] VEC        = 32'hBFC0_0200,
  parameter int          REG_STAT   = 16,
  parameter int          REG_SAVE   = 17
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            brkReq,
  input  logic            excReq,
  input  logic            instValid,
  input  logic [XLEN-1:0] instPc,
  input  logic            inDelaySlot,
  input  logic            cpValid,
  input  logic [4:0]      cpCode,
  input  logic [5:0]      cpFunct,
  input  logic [4:0]      cpReg,
  input  logic [XLEN-1:0] cpWData,
  input  logic            llSet,
  output logic            redirValid,
  output logic [XLEN-1:0] redirPc,
  output logic            cancelDs,
  output logic [XLEN-1:0] cpRData,
  output logic            debugMode,
  output logic            llValid
);

  dbgStrobe_t strb;
  logic       dmNow;

  dbg_ctl_seq #(.REG_STAT(REG_STAT), .REG_SAVE(REG_SAVE)) u_seq (
    .clk(clk), .rstN(rstN), .brkReq(brkReq), .instValid(instValid),
    .inDelaySlot(inDelaySlot), .cpValid(cpValid), .cpCode(cpCode),
    .cpFunct(cpFunct), .cpReg(cpReg), .dmNow(dmNow), .strb(strb),
    .redirValid(redirValid), .cancelDs(cancelDs)
  );

  dbg_ctl_dp #(
    .XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .VEC(VEC),
    .REG_STAT(REG_STAT), .REG_SAVE(REG_SAVE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .instPc(instPc), .cpWData(cpWData),
    .cpValid(cpValid), .cpCode(cpCode), .cpReg(cpReg), .brkReq(brkReq),
    .excReq(excReq), .llSet(llSet), .dmNow(dmNow), .redirPc(redirPc),
    .cpRData(cpRData), .llValid(llValid)
  );

  assign debugMode = dmNow;

endmodule

// File: rtl/dbg_entry_ctl_chk.sv
module dbg_entry_ctl_chk #(
  parameter int          XLEN = 32,
  parameter logic [31:0] VEC  = 32'hBFC0_0200
) (
  input logic            clk,
  input logic            rstN,
  input logic            brkReq,
  input logic            excReq,
  input logic            instValid,
  input logic            inDelaySlot,
  input logic            cpValid,
  input logic [4:0]      cpCode,
  input logic [5:0]      cpFunct,
  input logic            redirValid,
  input logic [XLEN-1:0] redirPc,
  input logic            cancelDs,
  input logic            debugMode,
  input logic            llValid
);

  // R2
  enter_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && !debugMode) |=> (redirValid && redirPc == XLEN'(VEC) && debugMode));

  // R4
  slot_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && !debugMode && inDelaySlot) |=> cancelDs);

  // R3
  no_slot_cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && !debugMode && !inDelaySlot) |=> !cancelDs);

  // R5
  suppressed_brk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq && debugMode && !instValid) |=> !redirValid);

  // R6
  ll_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brkReq || excReq) |=> !llValid);

  // R9
  dret_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpValid && cpCode == 5'h10 && cpFunct == 6'h1F && !(brkReq && !debugMode))
      |=> !debugMode);

endmodule

bind dbg_entry_ctl dbg_entry_ctl_chk #(.XLEN(XLEN), .VEC(VEC)) u_chk (
  .clk(clk), .rstN(rstN), .brkReq(brkReq), .excReq(excReq),
  .instValid(instValid), .inDelaySlot(inDelaySlot), .cpValid(cpValid),
  .cpCode(cpCode), .cpFunct(cpFunct), .redirValid(redirValid),
  .redirPc(redirPc), .cancelDs(cancelDs), .debugMode(debugMode),
  .llValid(llValid)
);

// File: tb/dbg_entry_ctl_tb.sv
module dbg_entry_ctl_tb;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] VEC        = 32'hBFC0_0200;

  logic        clk = 1'b0;
  logic        rstN;
  logic        brkReq, excReq, instValid, inDelaySlot, cpValid, llSet;
  logic [31:0] instPc, cpWData;
  logic [4:0]  cpCode, cpReg;
  logic [5:0]  cpFunct;
  logic        redirValid, cancelDs, debugMode, llValid;
  logic [31:0] redirPc, cpRData;

  int nChk  = 0;
  int nFail = 0;
  bit done  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dbg_entry_ctl u_dut (
    .clk(clk), .rstN(rstN), .brkReq(brkReq), .excReq(excReq),
    .instValid(instValid), .instPc(instPc), .inDelaySlot(inDelaySlot),
    .cpValid(cpValid), .cpCode(cpCode), .cpFunct(cpFunct), .cpReg(cpReg),
    .cpWData(cpWData), .llSet(llSet), .redirValid(redirValid),
    .redirPc(redirPc), .cancelDs(cancelDs), .cpRData(cpRData),
    .debugMode(debugMode), .llValid(llValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idleIn();
    brkReq = 0; excReq = 0; instValid = 0; inDelaySlot = 0; cpValid = 0;
    llSet = 0; instPc = '0; cpWData = '0; cpCode = '0; cpReg = '0; cpFunct = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input logic [4:0] r, output logic [31:0] v);
    cpValid = 1; cpCode = 5'h00; cpReg = r;
    #1 v = cpRData;
    cpValid = 0;
  endtask

  task automatic writeReg(input logic [4:0] r, input logic [31:0] d);
    cpValid = 1; cpCode = 5'h04; cpReg = r; cpWData = d;
    tick();
    idleIn();
  endtask

  task automatic dret();
    cpValid = 1; cpCode = 5'h10; cpFunct = 6'h1F;
    tick();
    idleIn();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] expSave;
    idleIn();
    rstN = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 redirValid", {31'b0, redirValid}, 32'h0);
    check("R1 cancelDs", {31'b0, cancelDs}, 32'h0);
    check("R1 llValid", {31'b0, llValid}, 32'h0);
    readReg(5'd16, v); check("R1 status", v, 32'h0);
    readReg(5'd17, v); check("R1 saved", v, 32'h0);
    rstN = 1;
    tick();
    check("R1 after release", {31'b0, redirValid}, 32'h0);

    // sweep addresses and delay-slot state: entry, suppressed entry, return
    for (int i = 0; i < 9; i++) begin
      for (int ds = 0; ds < 2; ds++) begin
        logic [31:0] pc;
        pc = (i == 8) ? 32'hFFFF_FFFC : (32'(i) * 32'h2468_1004);
        expSave = ds[0] ? pc - 32'd4 : pc;
        brkReq = 1; instPc = pc; inDelaySlot = ds[0];
        tick(); idleIn();
        check("R2 redirect", {31'b0, redirValid}, 32'h1);
        check("R2 vector", redirPc, VEC);
        check("R2 mode", {31'b0, debugMode}, 32'h1);
        check(ds[0] ? "R4 cancel" : "R3 cancel", {31'b0, cancelDs}, {31'b0, ds[0]});
        tick();
        check("R11 pulse", {31'b0, redirValid}, 32'h0);
        readReg(5'd16, v);
        check(ds[0] ? "R4 status" : "R3 status", v,
              {ds[0], 1'b1, 28'b0, 1'b1, 1'b0});
        readReg(5'd17, v);
        check(ds[0] ? "R4 saved" : "R3 saved", v, expSave);
        // suppressed request
        brkReq = 1; instPc = pc ^ 32'h0000_0010; inDelaySlot = ~ds[0];
        tick(); idleIn();
        check("R5 no redirect", {31'b0, redirValid}, 32'h0);
        readReg(5'd17, v); check("R5 saved kept", v, expSave);
        readReg(5'd16, v);
        check("R5 status kept", v, {ds[0], 1'b1, 28'b0, 1'b1, 1'b0});
        // return
        dret();
        check("R9 mode cleared", {31'b0, debugMode}, 32'h0);
        check("R9 no early jump", {31'b0, redirValid}, 32'h0);
        tick();
        check("R9 waits for slot", {31'b0, redirValid}, 32'h0);
        instValid = 1; tick(); idleIn();
        check("R9 return", {31'b0, redirValid}, 32'h1);
        check("R9 target", redirPc, expSave);
        tick();
        check("R11 return pulse", {31'b0, redirValid}, 32'h0);
      end
    end

    // R10 breakpoint and return in the same cycle
    brkReq = 1; instPc = 32'h0000_0100; cpValid = 1; cpCode = 5'h10; cpFunct = 6'h1F;
    tick(); idleIn();
    check("R10 same-cycle vector", redirPc, VEC);
    check("R10 same-cycle mode", {31'b0, debugMode}, 32'h1);
    instValid = 1; tick(); idleIn();
    check("R10 return discarded", {31'b0, redirValid}, 32'h0);
    dret(); instValid = 1; tick(); idleIn();
    check("R9 back to 0x100", redirPc, 32'h0000_0100);
    // R10 breakpoint cancels a waiting return
    brkReq = 1; instPc = 32'h0000_0200; tick(); idleIn();
    dret();
    brkReq = 1; instPc = 32'h0000_0300; tick(); idleIn();
    check("R10 new entry", redirPc, VEC);
    instValid = 1; tick(); idleIn();
    check("R10 pending cancelled", {31'b0, redirValid}, 32'h0);
    readReg(5'd17, v); check("R10 saved", v, 32'h0000_0300);
    dret(); instValid = 1; tick(); idleIn();
    check("R9 back to 0x300", redirPc, 32'h0000_0300);

    // R7 / R8 coprocessor moves
    writeReg(5'd16, 32'hFFFF_FFFF);
    readReg(5'd16, v); check("R8 masked status", v, 32'hC000_0002);
    check("R7 write sets mode", {31'b0, debugMode}, 32'h1);
    writeReg(5'd16, 32'h0);
    check("R7 write clears mode", {31'b0, debugMode}, 32'h0);
    writeReg(5'd16, 32'h3FFF_FFFD);
    readReg(5'd16, v); check("R8 unnamed bits", v, 32'h0);
    writeReg(5'd17, 32'h1357_2468);
    readReg(5'd17, v); check("R7 saved write", v, 32'h1357_2468);
    for (int r = 0; r < 32; r++) begin
      if (r != 16 && r != 17) begin
        writeReg(5'(r), 32'hFFFF_FFFF);
        readReg(5'(r), v); check("R7 other reg zero", v, 32'h0);
      end
    end
    readReg(5'd16, v); check("R7 status untouched", v, 32'h0);
    readReg(5'd17, v); check("R7 saved untouched", v, 32'h1357_2468);

    // R6 reservation flag
    llSet = 1; tick(); idleIn();
    check("R6 set", {31'b0, llValid}, 32'h1);
    excReq = 1; tick(); idleIn();
    check("R6 exception clears", {31'b0, llValid}, 32'h0);
    llSet = 1; tick(); llSet = 1; excReq = 1; tick(); idleIn();
    check("R6 clear wins", {31'b0, llValid}, 32'h0);
    writeReg(5'd16, 32'h4000_0000);
    llSet = 1; tick(); idleIn();
    brkReq = 1; tick(); idleIn();
    check("R6 suppressed brk clears", {31'b0, llValid}, 32'h0);
    check("R5 still no redirect", {31'b0, redirValid}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule